// File: doc/BRIEF.md
# Interrupt Request and Service Sequencer

This block lives in the control path of a small stored-program machine. It owns the 4-bit step counter and its one-hot timing decode. It also decides when an I/O device's ready flag turns into a taken interrupt. Once an interrupt is pending, it replaces the next instruction fetch with a three-step hardware cycle. That cycle stores the program counter into memory word 0 and leaves the program counter at 1, where software keeps a branch to its service routine.

A pending bit may latch only on a clock edge where none of the first three timing steps is active. It latches when interrupts are enabled and at least one of the input or output flags is raised. At the end of an instruction the rest of the control unit pulses `instr_done_i`, which returns the step counter to step 0. On that step the sequencer either enables the normal fetch (pending bit clear) or begins the save-and-branch cycle (pending bit set).

The block drives only plain control strobes to the datapath: address-register clear, temporary-register load from the program counter, memory write, program-counter clear and increment, interrupt-enable clear and step-counter clear. Nothing flows through it as a data stream, so there is no valid/ready handshake and no back-pressure. Each strobe is combinational from the current step and the pending bit, and takes effect at the next rising clock edge.

Top module: `irq_service_seq`

## Requirements
- R1: After reset, `timing_o` is one-hot with bit 0 set. Each clock edge moves the single set bit up by one position, wrapping from bit 15 to bit 0. A cycle with `instr_done_i` high, or with `sc_clr_o` high, makes bit 0 the set bit after the next edge.
- R2: `irq_pend_o` rises at an edge only if, in the cycle before that edge, `ien_i` was 1, at least one of `io_in_flag_i` and `io_out_flag_i` was 1, and none of `timing_o[0]`, `timing_o[1]`, `timing_o[2]` was set. It does not rise at an edge where any of those three timing bits was set.
- R3: `irq_pend_o` stays 0 when `ien_i` is 0 or both flags are 0. Once set, it stays 1 until the third service step.
- R4: `fetch_en_o[k]` (k = 0, 1, 2) is 1 exactly when `timing_o[k]` is set and `irq_pend_o` is 0.
- R5: Service step 1 is the cycle with `irq_pend_o` = 1 and `timing_o[0]` set. In it, `ar_clr_o` and `tr_load_o` are 1, so the address register becomes 0 and the temporary register takes the program counter.
- R6: Service step 2 is the cycle with `irq_pend_o` = 1 and `timing_o[1]` set. In it, `mem_wr_o` and `pc_clr_o` are 1, so the temporary register is written to the word at the address register and the program counter becomes 0.
- R7: Service step 3 is the cycle with `irq_pend_o` = 1 and `timing_o[2]` set. In it, `pc_inc_o`, `ien_clr_o` and `sc_clr_o` are 1. After that edge, `irq_pend_o` is 0 and `timing_o[0]` is set.
- R8: Suppose an interrupt becomes pending while the instruction at address 255 executes, with the program counter at 256. After the service cycle, memory word 0 holds 256, the program counter holds 1, and a normal fetch is enabled.
- R9: After the service cycle has cleared interrupt enable, raised flags do not set `irq_pend_o` again until interrupt enable is set once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ien_i | input | 1 | Current state of the interrupt-enable flip-flop |
| io_in_flag_i | input | 1 | Input device has a character ready |
| io_out_flag_i | input | 1 | Output device is ready for a character |
| instr_done_i | input | 1 | Last step of the current instruction; clears the step counter |
| timing_o | output | 16 | One-hot decoded step counter |
| irq_pend_o | output | 1 | Interrupt pending flip-flop |
| fetch_en_o | output | 3 | Fetch/decode step enables, gated by no pending interrupt |
| ar_clr_o | output | 1 | Clear address register (service step 1) |
| tr_load_o | output | 1 | Load temporary register from program counter (step 1) |
| mem_wr_o | output | 1 | Write temporary register to memory at address register (step 2) |
| pc_clr_o | output | 1 | Clear program counter (step 2) |
| pc_inc_o | output | 1 | Increment program counter (step 3) |
| ien_clr_o | output | 1 | Clear interrupt enable (step 3) |
| sc_clr_o | output | 1 | Clear step counter at end of service cycle (step 3) |

## Verification
The latch decision is exercised with enable and flag combinations applied at chosen timing steps. Steps 0 to 2 against later steps show that the fetch window is blocked. A cleared enable or two idle flags against a raised flag show that each condition is required. Each flag alone and both together show that either flag is enough. A full service cycle is run with a behavioural datapath, starting from an interrupt taken during the instruction at 255. That run separates correct strobe ordering from swapped or missing strobes through the final contents of word 0 and the program counter. A held flag after the cycle shows that the cleared enable keeps the request from retriggering, and setting the enable again shows that it is accepted once more.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  // Step counter width; timing decode has 2**SC_W one-hot lines.
  localparam int SC_W_DEF    = 4;
  // Number of leading steps reserved for fetch/decode or service.
  localparam int FETCH_STEPS = 3;

  typedef struct packed {
    logic ar_clr;
    logic tr_load;
    logic mem_wr;
    logic pc_clr;
    logic pc_inc;
    logic ien_clr;
    logic sc_clr;
  } svc_strobe_t;
endpackage

// File: rtl/irq_seq_timer.sv
module irq_seq_timer #(
  parameter int SC_W = 4,
  localparam int NSTEP = 1 << SC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  output logic [NSTEP-1:0] timing_o
);
  logic [SC_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // One-hot decode of the step counter.
  for (genvar s = 0; s < NSTEP; s++) begin : g_dec
    assign timing_o[s] = (cnt_q == SC_W'(s));
  end
endmodule

// File: rtl/irq_pend_ff.sv
module irq_pend_ff #(
  parameter int NLEAD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLEAD-1:0] lead_steps_i,
  input  logic             ien_i,
  input  logic             in_flag_i,
  input  logic             out_flag_i,
  input  logic             svc_done_i,
  output logic             pend_o
);
  logic may_latch;

  // Latching is blocked while any fetch/decode (or service) step runs.
  assign may_latch = ~(|lead_steps_i) & ien_i & (in_flag_i | out_flag_i);

  always_ff @(posedge clk) begin
    if (!rst_n)          pend_o <= 1'b0;
    else if (svc_done_i) pend_o <= 1'b0;
    else if (may_latch)  pend_o <= 1'b1;
  end
endmodule

// File: rtl/irq_step_ctl.sv
module irq_step_ctl
  import irq_seq_pkg::*;
#(
  parameter int NLEAD = 3
) (
  input  logic             pend_i,
  input  logic [NLEAD-1:0] lead_steps_i,
  output logic [NLEAD-1:0] fetch_en_o,
  output svc_strobe_t      strobe_o
);
  // Normal fetch/decode steps only when no interrupt is pending.
  for (genvar k = 0; k < NLEAD; k++) begin : g_fetch
    assign fetch_en_o[k] = lead_steps_i[k] & ~pend_i;
  end

  always_comb begin
    strobe_o         = '0;
    strobe_o.ar_clr  = pend_i & lead_steps_i[0];
    strobe_o.tr_load = pend_i & lead_steps_i[0];
    strobe_o.mem_wr  = pend_i & lead_steps_i[1];
    strobe_o.pc_clr  = pend_i & lead_steps_i[1];
    strobe_o.pc_inc  = pend_i & lead_steps_i[2];
    strobe_o.ien_clr = pend_i & lead_steps_i[2];
    strobe_o.sc_clr  = pend_i & lead_steps_i[2];
  end
endmodule

// File: rtl/irq_service_seq.sv
module irq_service_seq
  import irq_seq_pkg::*;
#(
  parameter int SC_W = SC_W_DEF,
  localparam int NSTEP = 1 << SC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ien_i,
  input  logic                   io_in_flag_i,
  input  logic                   io_out_flag_i,
  input  logic                   instr_done_i,
  output logic [NSTEP-1:0]       timing_o,
  output logic                   irq_pend_o,
  output logic [FETCH_STEPS-1:0] fetch_en_o,
  output logic                   ar_clr_o,
  output logic                   tr_load_o,
  output logic                   mem_wr_o,
  output logic                   pc_clr_o,
  output logic                   pc_inc_o,
  output logic                   ien_clr_o,
  output logic                   sc_clr_o
);
  svc_strobe_t            stb;
  logic [FETCH_STEPS-1:0] lead;

  assign lead = timing_o[FETCH_STEPS-1:0];

  irq_seq_timer #(.SC_W(SC_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (instr_done_i | stb.sc_clr),
    .timing_o (timing_o)
  );

  irq_pend_ff #(.NLEAD(FETCH_STEPS)) u_pend (
    .clk          (clk),
    .rst_n        (rst_n),
    .lead_steps_i (lead),
    .ien_i        (ien_i),
    .in_flag_i    (io_in_flag_i),
    .out_flag_i   (io_out_flag_i),
    .svc_done_i   (stb.pc_inc),
    .pend_o       (irq_pend_o)
  );

  irq_step_ctl #(.NLEAD(FETCH_STEPS)) u_ctl (
    .pend_i       (irq_pend_o),
    .lead_steps_i (lead),
    .fetch_en_o   (fetch_en_o),
    .strobe_o     (stb)
  );

  assign ar_clr_o  = stb.ar_clr;
  assign tr_load_o = stb.tr_load;
  assign mem_wr_o  = stb.mem_wr;
  assign pc_clr_o  = stb.pc_clr;
  assign pc_inc_o  = stb.pc_inc;
  assign ien_clr_o = stb.ien_clr;
  assign sc_clr_o  = stb.sc_clr;
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int NSTEP = 16,
  parameter int NLEAD = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ien_i,
  input logic             io_in_flag_i,
  input logic             io_out_flag_i,
  input logic             instr_done_i,
  input logic [NSTEP-1:0] timing_o,
  input logic             irq_pend_o,
  input logic [NLEAD-1:0] fetch_en_o,
  input logic             tr_load_o,
  input logic             mem_wr_o,
  input logic             pc_inc_o,
  input logic             ien_clr_o
);
  p_onehot_timing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(timing_o) == 1);

  p_done_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done_i |=> timing_o[0]);

  p_latch_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend_o) |-> $past(~(|timing_o[NLEAD-1:0]) && ien_i &&
                                (io_in_flag_i || io_out_flag_i)));

  p_pend_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend_o && !pc_inc_o) |=> irq_pend_o);

  p_fetch_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|fetch_en_o) |-> !irq_pend_o);

  p_step1_to_2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tr_load_o |=> mem_wr_o);

  p_step2_to_3_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |=> (pc_inc_o && ien_clr_o));

  p_exit_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc_o |=> (!irq_pend_o && timing_o[0]));
endmodule

bind irq_service_seq irq_seq_chk #(.NSTEP(NSTEP), .NLEAD(irq_seq_pkg::FETCH_STEPS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ien_i         (ien_i),
  .io_in_flag_i  (io_in_flag_i),
  .io_out_flag_i (io_out_flag_i),
  .instr_done_i  (instr_done_i),
  .timing_o      (timing_o),
  .irq_pend_o    (irq_pend_o),
  .fetch_en_o    (fetch_en_o),
  .tr_load_o     (tr_load_o),
  .mem_wr_o      (mem_wr_o),
  .pc_inc_o      (pc_inc_o),
  .ien_clr_o     (ien_clr_o)
);

// File: tb/irq_service_seq_tb_top.sv
module irq_service_seq_tb_top;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NV = 10;
  // {ien, in_flag, out_flag, expected_pend, step[3:0]}
  localparam logic [7:0] VEC [NV] = '{
    8'b1100_0000, 8'b1100_0001, 8'b1010_0010, 8'b1101_0011,
    8'b1011_0100, 8'b1111_1001, 8'b0110_0101, 8'b1000_0110,
    8'b1111_1111, 8'b0000_0111
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ien_i, io_in_flag_i, io_out_flag_i, instr_done_i;
  logic [15:0] timing_o;
  logic [2:0]  fetch_en_o;
  logic irq_pend_o, ar_clr_o, tr_load_o, mem_wr_o, pc_clr_o, pc_inc_o, ien_clr_o, sc_clr_o;

  // behavioural datapath
  logic          use_model = 1'b0;
  logic          ien_drv   = 1'b0;
  logic          ien_q     = 1'b0;
  logic [AW-1:0] pc = '0, ar = 12'h5A5, tr = '0;
  logic [DW-1:0] mem [16];

  assign ien_i = use_model ? ien_q : ien_drv;

  always @(posedge clk) begin
    if (pc_clr_o)      pc <= '0;
    else if (pc_inc_o) pc <= pc + 1'b1;
    if (ar_clr_o)  ar <= '0;
    if (tr_load_o) tr <= pc;
    if (mem_wr_o)  mem[ar[3:0]] <= DW'(tr);
    if (ien_clr_o) ien_q <= 1'b0;
  end

  irq_service_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ien_i(ien_i), .io_in_flag_i(io_in_flag_i),
    .io_out_flag_i(io_out_flag_i), .instr_done_i(instr_done_i),
    .timing_o(timing_o), .irq_pend_o(irq_pend_o), .fetch_en_o(fetch_en_o),
    .ar_clr_o(ar_clr_o), .tr_load_o(tr_load_o), .mem_wr_o(mem_wr_o),
    .pc_clr_o(pc_clr_o), .pc_inc_o(pc_inc_o), .ien_clr_o(ien_clr_o),
    .sc_clr_o(sc_clr_o)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; io_in_flag_i = 1'b0; io_out_flag_i = 1'b0; instr_done_i = 1'b0;
    ien_drv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_step(int k);
    while (timing_o != (16'd1 << k)) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    do_reset();

    // R1: reset state, advance, wrap, early clear
    chk("R1 reset timing", 32'(timing_o), 32'h1);
    chk("R1 reset pend", 32'(irq_pend_o), 32'h0);
    chk("R1 reset strobes", {ar_clr_o, tr_load_o, mem_wr_o, pc_clr_o, pc_inc_o, ien_clr_o, sc_clr_o}, 32'h0);
    chk("R4 reset fetch", 32'(fetch_en_o), 32'h1);
    @(negedge clk);
    chk("R1 advance", 32'(timing_o), 32'h2);
    repeat (15) @(negedge clk);
    chk("R1 wrap", 32'(timing_o), 32'h1);
    wait_step(6);
    instr_done_i = 1'b1;
    @(negedge clk);
    instr_done_i = 1'b0;
    chk("R1 done clears", 32'(timing_o), 32'h1);

    // vector table: latch decision vs step and conditions
    for (int i = 0; i < NV; i++) begin
      logic [7:0] v;
      v = VEC[i];
      do_reset();
      wait_step(int'(v[3:0]));
      ien_drv = v[7]; io_in_flag_i = v[6]; io_out_flag_i = v[5];
      @(negedge clk);
      chk((v[7] & (v[6] | v[5])) ? "R2 latch window" : "R3 latch blocked",
          32'(irq_pend_o), 32'(v[4]));
      ien_drv = 1'b0; io_in_flag_i = 1'b0; io_out_flag_i = 1'b0;
    end

    // directed: interrupt during instruction at 255
    do_reset();
    use_model = 1'b1;
    ien_q = 1'b1;
    pc = 12'd256;
    ar = 12'h0FF;
    wait_step(3);
    io_in_flag_i = 1'b1;
    @(negedge clk);                      // step 4
    chk("R3 pend set", 32'(irq_pend_o), 32'h1);
    instr_done_i = 1'b1;
    @(negedge clk);                      // step 0, pending
    instr_done_i = 1'b0;
    chk("R3 pend held", 32'(irq_pend_o), 32'h1);
    chk("R4 fetch blocked", 32'(fetch_en_o), 32'h0);
    chk("R5 step1 strobes", {ar_clr_o, tr_load_o, mem_wr_o, pc_clr_o}, 32'hC);
    @(negedge clk);                      // step 1
    chk("R5 ar cleared", 32'(ar), 32'h0);
    chk("R5 tr loaded", 32'(tr), 32'd256);
    chk("R6 step2 strobes", {tr_load_o, mem_wr_o, pc_clr_o, pc_inc_o}, 32'h6);
    @(negedge clk);                      // step 2
    chk("R6 word0 written", 32'(mem[0]), 32'd256);
    chk("R6 pc cleared", 32'(pc), 32'h0);
    chk("R7 step3 strobes", {mem_wr_o, pc_inc_o, ien_clr_o, sc_clr_o}, 32'h7);
    @(negedge clk);                      // back to step 0
    chk("R7 pend cleared", 32'(irq_pend_o), 32'h0);
    chk("R7 timing restart", 32'(timing_o), 32'h1);
    chk("R7 ien cleared", 32'(ien_q), 32'h0);
    chk("R8 pc is 1", 32'(pc), 32'h1);
    chk("R8 return addr", 32'(mem[0]), 32'd256);
    chk("R8 fetch enabled", 32'(fetch_en_o), 32'h1);

    // R9: flag held, enable off -> no retrigger; re-enable -> accepted
    begin
      logic seen;
      seen = 1'b0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (irq_pend_o) seen = 1'b1;
      end
      chk("R9 no retrigger", 32'(seen), 32'h0);
    end
    wait_step(5);
    ien_q = 1'b1;
    @(negedge clk);
    chk("R9 re-enabled", 32'(irq_pend_o), 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule